// File: doc/BRIEF.md
# ADC Capture Stream Buffer

This block moves converter samples from the domain of an external sample clock into an outbound word stream in the system clock domain. On every rising edge of the sample clock one sample is taken. In two-channel mode it holds both channels, and in one-channel mode it holds only channel A. The sample is packed into a 32-bit word and pushed into an internal dual-clock FIFO without ever stalling the converter. The system side empties the FIFO into a valid/ready stream whenever the downstream reader accepts data. Each word carries a destination stream index taken from a configuration input.

The FIFO absorbs short pauses of the reader. If the reader stops for long enough that the FIFO is full when a sample arrives, that sample is thrown away and the words already stored are kept. Each discard becomes a loss event. The event is carried into the system domain and lights a loss indicator. The indicator stays lit for a tenth of a second, counted in system clocks, after the most recent event.

Output stream rules: `out_data` and `out_stream` are valid while `out_valid` is high. A word is transferred on a rising `sys_clk` edge where both `out_valid` and `out_ready` are high. While `out_valid` is high and `out_ready` is low, the word and its index stay unchanged. The reader may hold `out_ready` low for as long as it likes, but once the FIFO fills, samples are lost. `cfg_dual` and `cfg_stream_id` are static settings. They may change only while both resets are asserted.

Top module: `adc_capture_buffer`

## Requirements
- R1: While the FIFO has room, every sample clock edge produces exactly one output word, and the words leave in capture order with none repeated or skipped.
- R2: With `cfg_dual` = 1, channel A sits in bits [15:0] and channel B in bits [31:16] of each output word.
- R3: With `cfg_dual` = 0, bits [15:0] carry channel A and bits [31:16] are zero.
- R4: `out_stream` equals `cfg_stream_id` for every word that is presented.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_stream` hold their values at the next clock.
- R6: With the reader halted, at least DEPTH consecutive samples are kept and are delivered unbroken once reading resumes.
- R7: A sample that arrives while the FIFO is full is discarded. The words after the discard continue forward in capture order, and nothing stored earlier is overwritten.
- R8: A discard lights `loss_led` within a few system clocks. The indicator rises only after a loss event and stays dark while no sample has been lost.
- R9: `loss_led` stays lit for SYS_HZ/10 system clocks after the most recent loss. A new loss restarts the count, and the indicator then goes dark.
- R10: After reset `out_valid` and `loss_led` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| smp_clk | input | 1 | External sample clock; one sample per rising edge |
| smp_rst_n | input | 1 | Active-low asynchronous reset, sample domain |
| adc_a | input | 16 | Channel A sample, valid at `smp_clk` rising edge |
| adc_b | input | 16 | Channel B sample, valid at `smp_clk` rising edge |
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Active-low asynchronous reset, system domain |
| cfg_dual | input | 1 | 1: two channels per word, 0: channel A only |
| cfg_stream_id | input | ID_W | Destination stream index sent with each word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Reader accepts the word this cycle |
| out_data | output | 32 | Packed sample word |
| out_stream | output | ID_W | Stream index of the presented word |
| loss_led | output | 1 | Sample-loss indicator, stretched |

## Verification
The capture path is tried with a free-running reader in two-channel mode, in one-channel mode and under an alternating ready pattern. Together these tell apart correct packing, correct zero extension, loss-free crossing when the reader keeps up, and word stability under back-pressure. A long reader stall then fills the FIFO. Counting the unbroken run before the first gap separates true retention of DEPTH words from overwriting or early dropping. Probing the indicator just before and just after SYS_HZ/10 clocks from the end of the stall separates a retriggered, correctly timed stretch from one that is too short, too long or never restarted.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

  localparam int SMP_W  = 16;
  localparam int WORD_W = 2 * SMP_W;

  typedef logic [SMP_W-1:0]  smp_t;
  typedef logic [WORD_W-1:0] word_t;

  // Channel A low half, channel B high half; single mode clears the high half.
  function automatic word_t pack_word(input logic dual, input smp_t a, input smp_t b);
    word_t w;
    w = {SMP_W'(0), a};
    if (dual) w[WORD_W-1:SMP_W] = b;
    return w;
  endfunction

endpackage

// File: rtl/adc_sample_packer.sv
module adc_sample_packer
  import adc_cap_pkg::*;
(
  input  logic  smp_clk,
  input  logic  smp_rst_n,
  input  logic  cfg_dual,
  input  smp_t  ch_a,
  input  smp_t  ch_b,
  output word_t pk_word,
  output logic  pk_vld
);

  always_ff @(posedge smp_clk or negedge smp_rst_n) begin
    if (!smp_rst_n) begin
      pk_word <= '0;
      pk_vld  <= 1'b0;
    end else begin
      pk_word <= pack_word(cfg_dual, ch_a, ch_b);
      pk_vld  <= 1'b1;
    end
  end

endmodule

// File: rtl/gray_ptr_sync.sv
module gray_ptr_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= '0;
      else if (i == 0) stage_q[i] <= d;
      else stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/adc_cdc_fifo.sv
module adc_cdc_fifo #(
  parameter int DEPTH  = 512,
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         wr_clk,
  input  logic         wr_rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         wr_full,
  input  logic         rd_clk,
  input  logic         rd_rst_n,
  input  logic         rd_pop,
  output logic [W-1:0] rd_data,
  output logic         rd_empty
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin_q, wgray_q, rbin_q, rgray_q;
  logic [PW-1:0] rgray_in_w, wgray_in_r;
  logic [PW-1:0] wbin_nx, rbin_nx;
  logic          wr_do;

  // Write side
  assign wr_full = (wgray_q == {~rgray_in_w[PW-1:PW-2], rgray_in_w[PW-3:0]});
  assign wr_do   = wr_en && !wr_full;
  assign wbin_nx = wbin_q + PW'(1);

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (wr_do) begin
      wbin_q  <= wbin_nx;
      wgray_q <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

  always_ff @(posedge wr_clk) begin
    if (wr_do) mem[wbin_q[AW-1:0]] <= wr_data;
  end

  // Read side
  assign rd_empty = (rgray_q == wgray_in_r);
  assign rd_data  = mem[rbin_q[AW-1:0]];
  assign rbin_nx  = rbin_q + PW'(1);

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (rd_pop && !rd_empty) begin
      rbin_q  <= rbin_nx;
      rgray_q <= rbin_nx ^ (rbin_nx >> 1);
    end
  end

  gray_ptr_sync #(.W(PW), .STAGES(STAGES)) u_rptr_to_w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray_q), .q(rgray_in_w)
  );

  gray_ptr_sync #(.W(PW), .STAGES(STAGES)) u_wptr_to_r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray_q), .q(wgray_in_r)
  );

endmodule

// File: rtl/loss_event_sync.sv
module loss_event_sync #(
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_evt,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse
);

  logic             tgl_q;
  logic [STAGES:0]  chain_q;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) tgl_q <= 1'b0;
    else if (src_evt) tgl_q <= ~tgl_q;
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) chain_q <= '0;
    else chain_q <= {chain_q[STAGES-1:0], tgl_q};
  end

  // Any change of the synchronized level marks one event.
  assign dst_pulse = chain_q[STAGES] ^ chain_q[STAGES-1];

endmodule

// File: rtl/loss_led_stretch.sv
module loss_led_stretch #(
  parameter int unsigned SYS_HZ = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  output logic led
);

  localparam int unsigned HOLD = SYS_HZ / 10;
  localparam int          CW   = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (evt) cnt_q <= CW'(HOLD);
    else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
  end

  assign led = (cnt_q != '0);

endmodule

// File: rtl/adc_capture_buffer.sv
module adc_capture_buffer
  import adc_cap_pkg::*;
#(
  parameter int          DEPTH  = 512,
  parameter int          ID_W   = 4,
  parameter int unsigned SYS_HZ = 100_000_000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              smp_clk,
  input  logic              smp_rst_n,
  input  logic [15:0]       adc_a,
  input  logic [15:0]       adc_b,
  input  logic              sys_clk,
  input  logic              sys_rst_n,
  input  logic              cfg_dual,
  input  logic [ID_W-1:0]   cfg_stream_id,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_data,
  output logic [ID_W-1:0]   out_stream,
  output logic              loss_led
);

  word_t pk_word, rd_data;
  logic  pk_vld, wr_full, wr_drop;
  logic  rd_empty, load;
  logic  loss_pulse;

  adc_sample_packer u_packer (
    .smp_clk(smp_clk), .smp_rst_n(smp_rst_n), .cfg_dual(cfg_dual),
    .ch_a(adc_a), .ch_b(adc_b), .pk_word(pk_word), .pk_vld(pk_vld)
  );

  adc_cdc_fifo #(.DEPTH(DEPTH), .W(WORD_W), .STAGES(SYNC_STAGES)) u_fifo (
    .wr_clk(smp_clk), .wr_rst_n(smp_rst_n), .wr_en(pk_vld),
    .wr_data(pk_word), .wr_full(wr_full),
    .rd_clk(sys_clk), .rd_rst_n(sys_rst_n), .rd_pop(load),
    .rd_data(rd_data), .rd_empty(rd_empty)
  );

  assign wr_drop = pk_vld && wr_full;

  loss_event_sync #(.STAGES(SYNC_STAGES)) u_loss_sync (
    .src_clk(smp_clk), .src_rst_n(smp_rst_n), .src_evt(wr_drop),
    .dst_clk(sys_clk), .dst_rst_n(sys_rst_n), .dst_pulse(loss_pulse)
  );

  loss_led_stretch #(.SYS_HZ(SYS_HZ)) u_stretch (
    .clk(sys_clk), .rst_n(sys_rst_n), .evt(loss_pulse), .led(loss_led)
  );

  // Output register: refill when empty or when the held word is taken.
  assign load = !rd_empty && (!out_valid || out_ready);

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_stream <= '0;
    end else if (load) begin
      out_valid  <= 1'b1;
      out_data   <= rd_data;
      out_stream <= cfg_stream_id;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_capture_checker.sv
module adc_capture_checker #(
  parameter int ID_W = 4
) (
  input logic            sys_clk,
  input logic            sys_rst_n,
  input logic            cfg_dual,
  input logic [ID_W-1:0] cfg_stream_id,
  input logic            out_valid,
  input logic            out_ready,
  input logic [31:0]     out_data,
  input logic [ID_W-1:0] out_stream,
  input logic            loss_led,
  input logic            loss_pulse
);

  a_r5_hold_stable: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_stream)));

  a_r3_single_high_zero: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (!cfg_dual && out_valid) |-> (out_data[31:16] == 16'h0));

  a_r4_stream_index: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    out_valid |-> (out_stream == cfg_stream_id));

  a_r8_led_follows_loss: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    loss_pulse |=> loss_led);

  a_r8_led_rise_has_cause: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    $rose(loss_led) |-> $past(loss_pulse));

endmodule

bind adc_capture_buffer adc_capture_checker #(.ID_W(ID_W)) i_chk (
  .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .cfg_dual(cfg_dual),
  .cfg_stream_id(cfg_stream_id), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_stream(out_stream), .loss_led(loss_led),
  .loss_pulse(loss_pulse)
);

// File: tb/test_adc_capture_buffer.sv
module test_adc_capture_buffer;

  localparam int          CLK_PERIOD = 10;
  localparam int          SMP_PERIOD = 30;
  localparam int          DEPTH      = 16;
  localparam int          ID_W       = 4;
  localparam int unsigned SYS_HZ     = 1000;
  localparam int          HOLD       = SYS_HZ / 10;

  logic            smp_clk = 0, sys_clk = 0;
  logic            smp_rst_n = 0, sys_rst_n = 0;
  logic [15:0]     adc_a, adc_b, seq;
  logic            cfg_dual = 1;
  logic [ID_W-1:0] cfg_stream_id = '0;
  logic            out_valid, out_ready = 0, loss_led;
  logic [31:0]     out_data;
  logic [ID_W-1:0] out_stream;

  int n_checks = 0;
  int n_fail   = 0;

  adc_capture_buffer #(.DEPTH(DEPTH), .ID_W(ID_W), .SYS_HZ(SYS_HZ)) i_adc_capture_buffer (
    .smp_clk(smp_clk), .smp_rst_n(smp_rst_n), .adc_a(adc_a), .adc_b(adc_b),
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .cfg_dual(cfg_dual),
    .cfg_stream_id(cfg_stream_id), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_stream(out_stream), .loss_led(loss_led)
  );

  initial forever #(CLK_PERIOD/2) sys_clk = ~sys_clk;
  initial forever #(SMP_PERIOD/2) smp_clk = ~smp_clk;

  // Converter model: a counter on channel A, a scrambled copy on channel B.
  initial begin
    seq = 16'h0;
    forever begin
      @(negedge smp_clk);
      seq = seq + 16'h1;
    end
  end
  assign adc_a = seq;
  assign adc_b = seq ^ 16'hA5A5;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic apply_reset(input bit dual, input logic [ID_W-1:0] id);
    @(negedge sys_clk);
    out_ready = 0;
    smp_rst_n = 0;
    sys_rst_n = 0;
    cfg_dual = dual;
    cfg_stream_id = id;
    repeat (6) @(negedge sys_clk);
    smp_rst_n = 1;
    sys_rst_n = 1;
  endtask

  // Receive n words; alt toggles ready every cycle; gap_ok allows forward jumps.
  task automatic recv(input int n, input bit alt, input bit dual,
                      input logic [ID_W-1:0] id, input bit gap_ok,
                      output int run, output int gaps);
    int got = 0;
    bit have_prev = 0;
    bit held = 0;
    logic [31:0] hd = '0;
    logic [15:0] prev = '0;
    logic [15:0] a, b;
    run = 0;
    gaps = 0;
    while (got < n) begin
      @(negedge sys_clk);
      if (held) begin
        check(out_valid && out_data == hd, "R5", "held word", out_data, hd);
        held = 0;
      end
      out_ready = alt ? ~out_ready : 1'b1;
      if (out_valid && out_ready) begin
        a = out_data[15:0];
        b = out_data[31:16];
        if (dual) check(b == (a ^ 16'hA5A5), "R2", "channel B half", {16'h0, b}, {16'h0, a ^ 16'hA5A5});
        else      check(b == 16'h0, "R3", "high half", {16'h0, b}, 32'h0);
        check(out_stream == id, "R4", "stream index", 32'(out_stream), 32'(id));
        if (have_prev) begin
          if (!gap_ok) begin
            check(a == prev + 16'h1, "R1", "sequence", {16'h0, a}, {16'h0, prev + 16'h1});
          end else if (a != prev + 16'h1) begin
            check((a - prev) > 16'h1 && (a - prev) < 16'h8000, "R7", "forward gap",
                  {16'h0, a}, {16'h0, prev + 16'h1});
            gaps++;
          end
        end
        if (gaps == 0) run++;
        prev = a;
        have_prev = 1;
        got++;
      end else if (out_valid) begin
        held = 1;
        hd = out_data;
      end
    end
    @(negedge sys_clk);
    out_ready = 0;
  endtask

  task automatic t_reset();
    apply_reset(1'b1, 4'd3);
    check(out_valid == 1'b0, "R10", "out_valid after reset", 32'(out_valid), 32'h0);
    check(loss_led == 1'b0, "R10", "loss_led after reset", 32'(loss_led), 32'h0);
  endtask

  task automatic t_dual_free();
    int run, gaps;
    apply_reset(1'b1, 4'd3);
    recv(40, 1'b0, 1'b1, 4'd3, 1'b0, run, gaps);
    check(loss_led == 1'b0, "R8", "no loss with free reader", 32'(loss_led), 32'h0);
  endtask

  task automatic t_single_free();
    int run, gaps;
    apply_reset(1'b0, 4'd9);
    recv(30, 1'b0, 1'b0, 4'd9, 1'b0, run, gaps);
    check(loss_led == 1'b0, "R8", "no loss in single mode", 32'(loss_led), 32'h0);
  endtask

  task automatic t_backpressure();
    int run, gaps;
    apply_reset(1'b1, 4'd5);
    recv(40, 1'b1, 1'b1, 4'd5, 1'b0, run, gaps);
    check(loss_led == 1'b0, "R8", "no loss at half rate", 32'(loss_led), 32'h0);
  endtask

  task automatic t_overflow();
    int run, gaps;
    apply_reset(1'b1, 4'd12);
    repeat (20) @(negedge sys_clk);
    check(loss_led == 1'b0, "R8", "dark before FIFO fills", 32'(loss_led), 32'h0);
    repeat (380) @(negedge sys_clk);
    // Stall far beyond one stretch period: still lit only if each loss retriggers.
    check(loss_led == 1'b1, "R9", "lit through long stall", 32'(loss_led), 32'h1);
    fork
      recv(60, 1'b0, 1'b1, 4'd12, 1'b1, run, gaps);
      begin
        repeat (HOLD - 2) @(negedge sys_clk);
        check(loss_led == 1'b1, "R9", "still lit before hold ends", 32'(loss_led), 32'h1);
        repeat (27) @(negedge sys_clk);
        check(loss_led == 1'b0, "R9", "dark after hold", 32'(loss_led), 32'h0);
      end
    join
    check(run >= DEPTH, "R6", "unbroken run after stall", 32'(run), 32'(DEPTH));
    check(gaps >= 1, "R7", "discard gap seen", 32'(gaps), 32'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_dual_free();
    t_single_free();
    t_backpressure();
    t_overflow();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule